// File: doc/BRIEF.md
# Change-Only Sample Recorder with Timestamped Clusters

The block watches a sample word that arrives with a valid strobe. A tick count arrives alongside it. Only samples whose value differs from the previous one are kept. Each kept value becomes an event, and events are grouped into fixed-size clusters written to a word-addressed buffer. Every cluster is one timestamp word followed by seven event words. The timestamp belongs to the first event of the cluster, and each later event in the same cluster sits exactly one tick after the one before it. Quiet stretches cost no storage. A consumer rebuilds the full waveform from the timestamps and the event values.

A quiet input could leave the gap between stored timestamps ambiguous once the tick count wraps. To prevent this, the block forces an event when the tick count has advanced by one less than its full range since the last stored event. Words leave through a write port that carries address, data and enable. The write pointer is also exported, split into a row field and a word-in-row field. When the pointer runs past the end of the buffer it wraps to zero and raises a sticky flag.

The tick input is expected to advance by one with each valid sample. Valid samples are spaced at least nine clock cycles apart, because closing a cluster can take up to eight buffer writes.

Top module: `rle_cluster_packer`

## Requirements
- R1: After a synchronous reset, `wr_en` is 0, `wr_pos` is 0 and `wrapped` is 0.
- R2: The first valid sample after reset is always stored. It opens a cluster at address 0, with the timestamp word written before the event word.
- R3: A valid sample equal to the previous valid sample produces no buffer write, except in the forced case of R7.
- R4: Each cluster occupies eight consecutive words aligned to a multiple of eight. The word at offset 0 holds the tick of the cluster's first event, zero-extended. Offsets 1 to 7 hold event values.
- R5: An event whose tick is exactly one more (modulo the tick range) than the previous stored event, with fewer than seven events in the open cluster, is written at the next address with no timestamp.
- R6: Any other event closes the open cluster. Its unused event slots are filled with the last stored event value, then a new timestamp word and the event word follow.
- R7: A valid sample whose tick is 2^TS_W − 1 ticks after the last stored event is stored even when its value is unchanged, and it opens a new cluster.
- R8: Writes go to strictly consecutive addresses. `wr_pos` always equals the address of the next write, with the row in its upper ROW_W bits and the word-in-row in its lower COL_W bits.
- R9: After writing the last address (all ones), the pointer returns to 0. `wrapped` rises with that write and stays 1 until reset.
- R10: With samples at least nine cycles apart, every command is taken by an idle writer. Decoding the buffer (timestamps, slot order, padding that repeats the previous word) reproduces every change point of the input exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 16 | Sample word |
| tick | input | 16 | Tick count of the current sample |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | 24 | Buffer word address |
| wr_data | output | 16 | Buffer write data |
| wr_pos | output | 24 | Address of the next write (row, word-in-row) |
| wrapped | output | 1 | Sticky flag, set when the pointer has wrapped |

## Verification
The states hardest to reach from the ports are the forced cluster after a full tick range of silence and the pointer wrap at the end of a 32768-row buffer. With default sizes, either one needs far more samples than a short run allows. The bench therefore builds the block with an 8-bit tick and 3 row bits, so that the same logic forces a cluster after 255 quiet samples and wraps after 4096 words. A dense toggling stream drives the pointer past the end. Padding is provoked by a change that arrives a few ticks after a short cluster. The written image is then decoded back into change points and compared with what was sent.

// File: rtl/rle_pack_pkg.sv
package rle_pack_pkg;
  // what the word writer emits in a given cycle
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_PAD   = 2'd1,
    WR_STAMP = 2'd2,
    WR_EVENT = 2'd3
  } wr_step_e;
endpackage

// File: rtl/rle_change_det.sv
module rle_change_det #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              is_change
);
  logic [DATA_W-1:0] prev_q;
  logic              seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (smp_valid) begin
      prev_q <= smp_data;
      seen_q <= 1'b1;
    end
  end

  // the first sample after reset always counts as a change
  assign is_change = smp_valid && (!seen_q || (smp_data != prev_q));
endmodule

// File: rtl/rle_cluster_ctrl.sv
module rle_cluster_ctrl #(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int EV_N   = 7,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [TS_W-1:0]   tick,
  input  logic              is_change,
  output logic              cmd_go,
  output logic [CNT_W-1:0]  cmd_pad,
  output logic [DATA_W-1:0] cmd_pad_val,
  output logic              cmd_stamp,
  output logic [TS_W-1:0]   cmd_ts,
  output logic [DATA_W-1:0] cmd_val
);
  localparam logic [TS_W-1:0]  GAP_MAX = '1;
  localparam logic [TS_W-1:0]  ONE_TICK = TS_W'(1);
  localparam logic [CNT_W-1:0] EV_LIM  = CNT_W'(EV_N);

  logic              open_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TS_W-1:0]   last_tick_q;
  logic [DATA_W-1:0] last_val_q;

  logic [TS_W-1:0] since;
  logic            forced;
  logic            take;
  logic            append;

  always_comb begin
    since  = tick - last_tick_q;
    forced = smp_valid && open_q && (since == GAP_MAX);
    take   = is_change || forced;
    append = take && open_q && (cnt_q < EV_LIM) && (since == ONE_TICK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      cnt_q       <= '0;
      last_tick_q <= '0;
      last_val_q  <= '0;
      cmd_go      <= 1'b0;
      cmd_pad     <= '0;
      cmd_pad_val <= '0;
      cmd_stamp   <= 1'b0;
      cmd_ts      <= '0;
      cmd_val     <= '0;
    end else begin
      cmd_go <= take;
      if (take) begin
        cmd_val     <= smp_data;
        last_tick_q <= tick;
        last_val_q  <= smp_data;
        open_q      <= 1'b1;
        if (append) begin
          cnt_q     <= cnt_q + CNT_W'(1);
          cmd_stamp <= 1'b0;
          cmd_pad   <= '0;
        end else begin
          cnt_q       <= CNT_W'(1);
          cmd_stamp   <= 1'b1;
          cmd_ts      <= tick;
          cmd_pad     <= open_q ? (EV_LIM - cnt_q) : '0;
          cmd_pad_val <= last_val_q;
        end
      end
    end
  end
endmodule

// File: rtl/rle_word_writer.sv
module rle_word_writer
  import rle_pack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic [CNT_W-1:0]  cmd_pad,
  input  logic [DATA_W-1:0] cmd_pad_val,
  input  logic              cmd_stamp,
  input  logic [TS_W-1:0]   cmd_ts,
  input  logic [DATA_W-1:0] cmd_val,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_pos,
  output logic              wrapped,
  output logic              idle
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [CNT_W-1:0]  pad_left_q;
  logic [DATA_W-1:0] pad_val_q;
  logic              stamp_q;
  logic [TS_W-1:0]   ts_q;
  logic              ev_q;
  logic [DATA_W-1:0] ev_val_q;
  logic [ADDR_W-1:0] ptr_q;

  wr_step_e          step;
  logic [DATA_W-1:0] emit;

  always_comb begin
    if (pad_left_q != '0)  step = WR_PAD;
    else if (stamp_q)      step = WR_STAMP;
    else if (ev_q)         step = WR_EVENT;
    else                   step = WR_IDLE;
    case (step)
      WR_PAD:   emit = pad_val_q;
      WR_STAMP: emit = DATA_W'(ts_q);
      WR_EVENT: emit = ev_val_q;
      default:  emit = '0;
    endcase
  end

  assign idle   = (step == WR_IDLE);
  assign wr_pos = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_left_q <= '0;
      pad_val_q  <= '0;
      stamp_q    <= 1'b0;
      ts_q       <= '0;
      ev_q       <= 1'b0;
      ev_val_q   <= '0;
      ptr_q      <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wrapped    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cmd_go) begin
        pad_left_q <= cmd_pad;
        pad_val_q  <= cmd_pad_val;
        stamp_q    <= cmd_stamp;
        ts_q       <= cmd_ts;
        ev_q       <= 1'b1;
        ev_val_q   <= cmd_val;
      end else if (step != WR_IDLE) begin
        wr_en   <= 1'b1;
        wr_addr <= ptr_q;
        wr_data <= emit;
        ptr_q   <= ptr_q + ADDR_W'(1);
        if (ptr_q == LAST_ADDR) wrapped <= 1'b1;
        case (step)
          WR_PAD:   pad_left_q <= pad_left_q - CNT_W'(1);
          WR_STAMP: stamp_q    <= 1'b0;
          default:  ev_q       <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rle_cluster_packer.sv
module rle_cluster_packer #(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int ROW_W  = 15,
  parameter int COL_W  = 9,
  parameter int EV_N   = 7,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(EV_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [TS_W-1:0]   tick,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_pos,
  output logic              wrapped
);
  logic              is_change;
  logic              cmd_go;
  logic [CNT_W-1:0]  cmd_pad;
  logic [DATA_W-1:0] cmd_pad_val;
  logic              cmd_stamp;
  logic [TS_W-1:0]   cmd_ts;
  logic [DATA_W-1:0] cmd_val;
  logic              wr_idle;

  rle_change_det #(.DATA_W(DATA_W)) u_det (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .is_change (is_change)
  );

  rle_cluster_ctrl #(
    .DATA_W (DATA_W),
    .TS_W   (TS_W),
    .EV_N   (EV_N),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .tick        (tick),
    .is_change   (is_change),
    .cmd_go      (cmd_go),
    .cmd_pad     (cmd_pad),
    .cmd_pad_val (cmd_pad_val),
    .cmd_stamp   (cmd_stamp),
    .cmd_ts      (cmd_ts),
    .cmd_val     (cmd_val)
  );

  rle_word_writer #(
    .DATA_W (DATA_W),
    .TS_W   (TS_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_wr (
    .clk         (clk),
    .rst         (rst),
    .cmd_go      (cmd_go),
    .cmd_pad     (cmd_pad),
    .cmd_pad_val (cmd_pad_val),
    .cmd_stamp   (cmd_stamp),
    .cmd_ts      (cmd_ts),
    .cmd_val     (cmd_val),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_pos      (wr_pos),
    .wrapped     (wrapped),
    .idle        (wr_idle)
  );
endmodule

// File: rtl/rle_cluster_packer_chk.sv
module rle_cluster_packer_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_go,
  input logic              wr_idle,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] wr_pos,
  input logic              wrapped
);
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> wr_idle); // R10

  AST_ADDR_NEXT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_pos == wr_addr + ADDR_W'(1))); // R8

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> $stable(wr_pos)); // R8

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    wrapped |=> wrapped); // R9

  AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(wrapped) |-> (wr_en && (wr_addr == '1))); // R9
endmodule

bind rle_cluster_packer rle_cluster_packer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cmd_go  (cmd_go),
  .wr_idle (wr_idle),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_pos  (wr_pos),
  .wrapped (wrapped)
);

// File: tb/rle_cluster_packer_tb.sv
module rle_cluster_packer_tb_top;
  localparam int TSW   = 8;
  localparam int ROWW  = 3;
  localparam int COLW  = 9;
  localparam int AW    = ROWW + COLW;
  localparam int DEPTH = 1 << AW;
  localparam int TMASK = (1 << TSW) - 1;
  localparam int EVN   = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [15:0]   smp_data = '0;
  logic [TSW-1:0] tick = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic [AW-1:0] wr_pos;
  logic          wrapped;

  always #5 clk = ~clk;

  rle_cluster_packer #(.DATA_W(16), .TS_W(TSW), .ROW_W(ROWW), .COL_W(COLW), .EV_N(EVN)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_pos(wr_pos), .wrapped(wrapped)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int wcount = 0;

  // reference model state
  int exp_addr[$];
  int exp_data[$];
  string exp_tag[$];
  bit m_open = 0;
  int m_cnt = 0;
  int m_last_tick = 0;
  int m_last_val = 0;
  int m_prev = 0;
  int m_ptr = 0;
  bit m_wrapped = 0;
  int idx = 0;
  int in_t[$];
  int in_v[$];
  logic [15:0] mem [DEPTH];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input int d, input string tag);
    exp_addr.push_back(m_ptr);
    exp_data.push_back(d);
    exp_tag.push_back(tag);
    m_ptr = (m_ptr + 1) % DEPTH;
  endtask

  task automatic model(input int val, input int t);
    int since;
    bit take;
    since = (t - m_last_tick) & TMASK;
    take = !m_open || (val != m_prev) || (since == TMASK);
    if (take) begin
      if (m_open && m_cnt < EVN && since == 1) begin
        push(val, "R5");
        m_cnt++;
      end else begin
        if (m_open) for (int k = m_cnt; k < EVN; k++) push(m_last_val, "R6");
        push(t, "R4");
        push(val, !m_open ? "R2" : ((val == m_prev) ? "R7" : "R6"));
        m_cnt = 1;
        m_open = 1;
      end
      m_last_tick = t;
      m_last_val = val;
    end
    m_prev = val;
  endtask

  task automatic send(input int val);
    int t;
    t = idx & TMASK;
    if (idx == 0 || val != in_v[in_v.size()-1]) begin
      in_t.push_back(idx);
      in_v.push_back(val);
    end
    model(val, t);
    smp_valid = 1'b1;
    smp_data = 16'(val);
    tick = TSW'(t);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (8) @(negedge clk);
    idx++;
  endtask

  // compare every write against the model queue
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (!rst && wr_en) begin
        int a, d;
        string tg;
        wcount++;
        mem[wr_addr] = wr_data;
        if (exp_addr.size() == 0) begin
          check(0, "R3 unexpected write", int'(wr_addr), -1);
        end else begin
          a = exp_addr.pop_front();
          d = exp_data.pop_front();
          tg = exp_tag.pop_front();
          check(int'(wr_addr) == a && int'(wr_data) == d, tg, int'({wr_addr, wr_data}), (a << 16) | d);
          if (a == DEPTH - 1) m_wrapped = 1;
          check(int'(wr_pos) == (a + 1) % DEPTH, "R8 pos", int'(wr_pos), (a + 1) % DEPTH);
          check(wrapped == m_wrapped, "R9 flag", int'(wrapped), int'(m_wrapped));
        end
      end
    end
  end

  task automatic reconstruct();
    int pos, last_abs, cur, rv, prevw, n;
    bit started;
    int rc_t[$];
    int rc_v[$];
    pos = int'(wr_pos);
    last_abs = 0; cur = 0; rv = -1; prevw = 0; started = 0;
    for (int a = 0; a < pos; a++) begin
      int slot, w, t;
      slot = a % 8;
      w = int'(mem[a]);
      if (slot == 0) begin
        cur = started ? last_abs + ((w - last_abs) & TMASK) : w;
        started = 1;
      end else begin
        if (!(slot >= 2 && w == prevw)) begin
          t = (slot == 1) ? cur : last_abs + 1;
          if (w != rv) begin
            rc_t.push_back(t);
            rc_v.push_back(w);
          end
          rv = w;
          last_abs = t;
        end
        prevw = w;
      end
    end
    check(rc_t.size() == in_t.size(), "R10 change count", rc_t.size(), in_t.size());
    n = (rc_t.size() < in_t.size()) ? rc_t.size() : in_t.size();
    for (int i = 0; i < n; i++)
      check(rc_t[i] == in_t[i] && rc_v[i] == in_v[i], "R10 change point",
            (rc_t[i] << 16) | rc_v[i], (in_t[i] << 16) | in_v[i]);
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
    check(wr_pos == '0, "R1 wr_pos", int'(wr_pos), 0);
    check(wrapped == 1'b0, "R1 wrapped", int'(wrapped), 0);
    rst = 1'b0;
    @(negedge clk);

    send(16'h1234);                                   // R2 first sample
    for (int i = 1; i <= 10; i++) send(16'h1234 + i); // R5 run, full cluster then new
    repeat (4) @(negedge clk);
    snap = wcount;
    for (int i = 0; i < 50; i++) send(16'h123E);      // R3 unchanged
    check(wcount == snap, "R3 quiet writes", wcount - snap, 0);
    send(16'h0F0F);
    repeat (3) send(16'h0F0F);
    send(16'hF0F0);                                   // R6 gap closes with padding
    send(16'h00FF);                                   // R5 append
    for (int i = 0; i < 300; i++) send(16'h00FF);     // R7 forced after 255 quiet ticks
    send(16'hBEEF);
    send(16'hCAFE);
    repeat (12) @(negedge clk);
    check(exp_addr.size() == 0, "R10 drained", exp_addr.size(), 0);
    reconstruct();

    for (int i = 0; i < 3900; i++) send((i & 1) ? 16'hA5A5 : 16'h5A5A); // R9 wrap
    repeat (12) @(negedge clk);
    check(exp_addr.size() == 0, "R10 drained end", exp_addr.size(), 0);
    check(wrapped == 1'b1, "R9 wrapped end", int'(wrapped), 1);
    check(int'(wr_pos) == m_ptr, "R8 final pos", int'(wr_pos), m_ptr);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule